// File: doc/BRIEF.md
# Vector Interleave and 4x4 Word Transpose Unit

This block is a permute unit for a 128-bit SIMD datapath. Its single-operation path takes two source vectors and builds a result by alternating elements from them. The source that supplies the even result positions is called the even source; the other is the odd source. The low mode draws elements from the lower half of both sources, and the high mode draws them from the upper half. Elements are either 32-bit words or 64-bit doublewords. The result is registered, so it appears one cycle after the request.

Beside this path sits a sequencer. It captures four rows of four 32-bit words in one cycle. It then runs a fixed schedule of eight interleaves: a low and a high word interleave on rows 0 and 1, the same on rows 2 and 3, and finally four doubleword interleaves on those four intermediates. The schedule runs on two interleave cores, two operations per cycle, over four cycles. At the end the block presents the four columns of the input block as four output rows.

Top module: `ilv_xpose_unit`

## Requirements
- R1: Lane k of a vector is bits [32k+31:32k] (lane 0 is least significant). With op_hi_i=0 and op_wide_i=0, the result lanes 0..3 are even[0], odd[0], even[1], odd[1].
- R2: With op_hi_i=1 and op_wide_i=0, the result lanes 0..3 are even[2], odd[2], even[3], odd[3].
- R3: With op_hi_i=0 and op_wide_i=1, result bits [63:0] are even bits [63:0] and result bits [127:64] are odd bits [63:0].
- R4: With op_hi_i=1 and op_wide_i=1, result bits [63:0] are even bits [127:64] and result bits [127:64] are odd bits [127:64].
- R5: res_valid_o is high in exactly the cycle after op_valid_i was high, and res_o then holds that operation's result; when op_valid_i is low, res_o keeps its previous value.
- R6: After a sequence, lane j of xp_col<i>_o equals lane i of the captured xp_row<j>_i, for all i and j in 0..3.
- R7: A start sampled while xp_busy_o is low captures the rows; xp_busy_o is then high for exactly four cycles, and xp_done_o is high in the following cycle with xp_busy_o low.
- R8: A start sampled while xp_busy_o is high is ignored: the running sequence finishes on its normal cycle with the columns of the rows it captured, and no extra done pulse follows.
- R9: After reset, xp_busy_o, xp_done_o and res_valid_o are low, and res_o and all xp_col outputs are zero.
- R10: xp_done_o is a single-cycle pulse; the column outputs keep their values after done until the next accepted start. A start in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Single interleave request |
| op_hi_i | input | 1 | 0 = lower halves, 1 = upper halves |
| op_wide_i | input | 1 | 0 = 32-bit elements, 1 = 64-bit elements |
| op_even_i | input | 128 | Source for the even result positions |
| op_odd_i | input | 128 | Source for the odd result positions |
| res_valid_o | output | 1 | Result valid, one cycle after a request |
| res_o | output | 128 | Interleave result |
| xp_start_i | input | 1 | Start a transpose sequence |
| xp_row0_i | input | 128 | Input row 0 |
| xp_row1_i | input | 128 | Input row 1 |
| xp_row2_i | input | 128 | Input row 2 |
| xp_row3_i | input | 128 | Input row 3 |
| xp_busy_o | output | 1 | Sequence running |
| xp_done_o | output | 1 | Columns ready (one-cycle pulse) |
| xp_col0_o | output | 128 | Column 0 of the block |
| xp_col1_o | output | 128 | Column 1 of the block |
| xp_col2_o | output | 128 | Column 2 of the block |
| xp_col3_o | output | 128 | Column 3 of the block |

## Verification
The assertions check on every cycle the valid timing of the operation path and its hold behaviour. They also check that done is a lone pulse with busy low, that busy lasts exactly four cycles from an accepted start, and that a start during a run neither restarts it nor changes its data. Finally, they check that each done presents the full transpose of the rows captured at the start. Only the bench scenarios show the exact lane placement of each of the four interleave modes on chosen patterns. The same holds for the reset values, the acceptance of a start in the done cycle, and the columns holding after done.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    localparam int ROWS = 4;

    // Slot read as the even source at each sequencer step; the low result returns to it.
    function automatic logic [1:0] ev_slot(input logic [1:0] step);
        case (step)
            2'd0:    return 2'd0;
            2'd1:    return 2'd2;
            2'd2:    return 2'd0;
            default: return 2'd1;
        endcase
    endfunction

    // Slot read as the odd source at each step; the high result returns to it.
    function automatic logic [1:0] od_slot(input logic [1:0] step);
        case (step)
            2'd0:    return 2'd1;
            2'd1:    return 2'd3;
            2'd2:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // First two steps use word elements, last two doubleword elements.
    function automatic logic step_wide(input logic [1:0] step);
        return step[1];
    endfunction

    // Slot holding output column c once the schedule has finished.
    function automatic int col_slot(input int c);
        case (c)
            0:       return 0;
            1:       return 2;
            2:       return 1;
            default: return 3;
        endcase
    endfunction
endpackage

// File: rtl/ilv_core.sv
module ilv_core #(
    parameter int DW = 128,
    parameter int EW = 32
) (
    input  logic [DW-1:0] ev_i,
    input  logic [DW-1:0] od_i,
    input  logic          hi_i,
    input  logic          wide_i,
    output logic [DW-1:0] res_o
);
    localparam int NN = DW / EW;
    localparam int WW = 2 * EW;
    localparam int NW = DW / WW;

    logic [DW-1:0] nar;
    logic [DW-1:0] wid;

    for (genvar k = 0; k < NN / 2; k++) begin : g_nar
        assign nar[2*k*EW +: EW]     = hi_i ? ev_i[(k+NN/2)*EW +: EW] : ev_i[k*EW +: EW];
        assign nar[(2*k+1)*EW +: EW] = hi_i ? od_i[(k+NN/2)*EW +: EW] : od_i[k*EW +: EW];
    end

    for (genvar k = 0; k < NW / 2; k++) begin : g_wid
        assign wid[2*k*WW +: WW]     = hi_i ? ev_i[(k+NW/2)*WW +: WW] : ev_i[k*WW +: WW];
        assign wid[(2*k+1)*WW +: WW] = hi_i ? od_i[(k+NW/2)*WW +: WW] : od_i[k*WW +: WW];
    end

    assign res_o = wide_i ? wid : nar;
endmodule

// File: rtl/ilv_op_stage.sv
module ilv_op_stage #(
    parameter int DW = 128,
    parameter int EW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          valid_i,
    input  logic          hi_i,
    input  logic          wide_i,
    input  logic [DW-1:0] ev_i,
    input  logic [DW-1:0] od_i,
    output logic          valid_o,
    output logic [DW-1:0] res_o
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] res;
    } op_st_t;

    op_st_t        st_d, st_q;
    logic [DW-1:0] core_res;

    ilv_core #(.DW(DW), .EW(EW)) core_i (
        .ev_i  (ev_i),
        .od_i  (od_i),
        .hi_i  (hi_i),
        .wide_i(wide_i),
        .res_o (core_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) begin
            st_d.res = core_res;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign valid_o = st_q.vld;
    assign res_o   = st_q.res;
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         start_i,
    input  logic [ROWS-1:0][ROWS*EW-1:0] rows_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [ROWS-1:0][ROWS*EW-1:0] cols_o
);
    localparam int DW = ROWS * EW;

    typedef struct packed {
        logic                   busy;
        logic                   done;
        logic [1:0]             step;
        logic [ROWS-1:0][DW-1:0] slot;
    } seq_st_t;

    seq_st_t      st_d, st_q;
    logic [DW-1:0] ev_op, od_op;
    logic [1:0][DW-1:0] core_res;   // [0] low half, [1] high half

    assign ev_op = st_q.slot[ev_slot(st_q.step)];
    assign od_op = st_q.slot[od_slot(st_q.step)];

    for (genvar g = 0; g < 2; g++) begin : g_core
        ilv_core #(.DW(DW), .EW(EW)) core_i (
            .ev_i  (ev_op),
            .od_i  (od_op),
            .hi_i  (g[0]),
            .wide_i(step_wide(st_q.step)),
            .res_o (core_res[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.slot = rows_i;
                st_d.busy = 1'b1;
                st_d.step = 2'd0;
            end
        end else begin
            st_d.slot[ev_slot(st_q.step)] = core_res[0];
            st_d.slot[od_slot(st_q.step)] = core_res[1];
            st_d.step = st_q.step + 2'd1;
            if (st_q.step == 2'd3) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar c = 0; c < ROWS; c++) begin : g_col
        assign cols_o[c] = st_q.slot[col_slot(c)];
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
endmodule

// File: rtl/ilv_xpose_unit.sv
module ilv_xpose_unit
    import ilv_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               op_valid_i,
    input  logic               op_hi_i,
    input  logic               op_wide_i,
    input  logic [ROWS*EW-1:0] op_even_i,
    input  logic [ROWS*EW-1:0] op_odd_i,
    output logic               res_valid_o,
    output logic [ROWS*EW-1:0] res_o,
    input  logic               xp_start_i,
    input  logic [ROWS*EW-1:0] xp_row0_i,
    input  logic [ROWS*EW-1:0] xp_row1_i,
    input  logic [ROWS*EW-1:0] xp_row2_i,
    input  logic [ROWS*EW-1:0] xp_row3_i,
    output logic               xp_busy_o,
    output logic               xp_done_o,
    output logic [ROWS*EW-1:0] xp_col0_o,
    output logic [ROWS*EW-1:0] xp_col1_o,
    output logic [ROWS*EW-1:0] xp_col2_o,
    output logic [ROWS*EW-1:0] xp_col3_o
);
    localparam int DW = ROWS * EW;

    logic [ROWS-1:0][DW-1:0] rows;
    logic [ROWS-1:0][DW-1:0] cols;

    assign rows = {xp_row3_i, xp_row2_i, xp_row1_i, xp_row0_i};

    ilv_op_stage #(.DW(DW), .EW(EW)) op_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .valid_i(op_valid_i),
        .hi_i   (op_hi_i),
        .wide_i (op_wide_i),
        .ev_i   (op_even_i),
        .od_i   (op_odd_i),
        .valid_o(res_valid_o),
        .res_o  (res_o)
    );

    ilv_seq #(.EW(EW)) seq_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(xp_start_i),
        .rows_i (rows),
        .busy_o (xp_busy_o),
        .done_o (xp_done_o),
        .cols_o (cols)
    );

    assign xp_col0_o = cols[0];
    assign xp_col1_o = cols[1];
    assign xp_col2_o = cols[2];
    assign xp_col3_o = cols[3];
endmodule

// File: rtl/ilv_xpose_chk.sv
module ilv_xpose_chk #(
    parameter int EW = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               op_valid_i,
    input logic               res_valid_o,
    input logic [4*EW-1:0]    res_o,
    input logic               xp_start_i,
    input logic [4*EW-1:0]    xp_row0_i,
    input logic [4*EW-1:0]    xp_row1_i,
    input logic [4*EW-1:0]    xp_row2_i,
    input logic [4*EW-1:0]    xp_row3_i,
    input logic               xp_busy_o,
    input logic               xp_done_o,
    input logic [4*EW-1:0]    xp_col0_o,
    input logic [4*EW-1:0]    xp_col1_o,
    input logic [4*EW-1:0]    xp_col2_o,
    input logic [4*EW-1:0]    xp_col3_o
);
    localparam int DW = 4 * EW;

    logic [3:0][DW-1:0] cap_q;
    logic [2:0]         run_cnt_q;
    logic [3:0][DW-1:0] cols;

    assign cols = {xp_col3_o, xp_col2_o, xp_col1_o, xp_col0_o};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q     <= '0;
            run_cnt_q <= '0;
        end else if (xp_start_i && !xp_busy_o) begin
            cap_q     <= {xp_row3_i, xp_row2_i, xp_row1_i, xp_row0_i};
            run_cnt_q <= '0;
        end else if (xp_busy_o) begin
            run_cnt_q <= run_cnt_q + 3'd1;
        end
    end

    function automatic logic is_xpose(input logic [3:0][DW-1:0] r,
                                      input logic [3:0][DW-1:0] c);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                if (c[i][j*EW +: EW] != r[j][i*EW +: EW]) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    p_res_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_valid_i |=> res_valid_o);
    p_res_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_valid_i |=> (!res_valid_o && $stable(res_o)));
    p_xpose_ok_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xp_done_o |-> is_xpose(cap_q, cols));
    p_start_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xp_start_i && !xp_busy_o) |=> xp_busy_o);
    p_run_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xp_done_o |-> (run_cnt_q == 3'd4 && !xp_busy_o));
    p_busy_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xp_busy_o && run_cnt_q == 3'd3) |=> (xp_done_o && !xp_busy_o));
    p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xp_busy_o && run_cnt_q != 3'd3) |=> (xp_busy_o && $stable(cap_q)));
    p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xp_done_o |=> !xp_done_o);
    p_cols_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!xp_busy_o && !xp_start_i) |=> $stable(cols));
endmodule

bind ilv_xpose_unit ilv_xpose_chk #(.EW(EW)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .res_valid_o(res_valid_o),
    .res_o      (res_o),
    .xp_start_i (xp_start_i),
    .xp_row0_i  (xp_row0_i),
    .xp_row1_i  (xp_row1_i),
    .xp_row2_i  (xp_row2_i),
    .xp_row3_i  (xp_row3_i),
    .xp_busy_o  (xp_busy_o),
    .xp_done_o  (xp_done_o),
    .xp_col0_o  (xp_col0_o),
    .xp_col1_o  (xp_col1_o),
    .xp_col2_o  (xp_col2_o),
    .xp_col3_o  (xp_col3_o)
);

// File: tb/ilv_xpose_unit_tb_top.sv
module ilv_xpose_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0, op_hi = 1'b0, op_wide = 1'b0;
    logic [127:0] op_even = '0, op_odd = '0;
    logic res_valid;
    logic [127:0] res;
    logic xp_start = 1'b0;
    logic [127:0] row0 = '0, row1 = '0, row2 = '0, row3 = '0;
    logic xp_busy, xp_done;
    logic [127:0] col0, col1, col2, col3;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    ilv_xpose_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .op_valid_i(op_valid), .op_hi_i(op_hi), .op_wide_i(op_wide),
        .op_even_i(op_even), .op_odd_i(op_odd),
        .res_valid_o(res_valid), .res_o(res),
        .xp_start_i(xp_start),
        .xp_row0_i(row0), .xp_row1_i(row1), .xp_row2_i(row2), .xp_row3_i(row3),
        .xp_busy_o(xp_busy), .xp_done_o(xp_done),
        .xp_col0_o(col0), .xp_col1_o(col1), .xp_col2_o(col2), .xp_col3_o(col3)
    );

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ln(input logic [127:0] v, input int k);
        return v[32*k +: 32];
    endfunction

    // Expected result written from the lane lists in R1..R4.
    function automatic logic [127:0] exp_op(input logic hi, input logic wide,
                                            input logic [127:0] e, input logic [127:0] o);
        if (!wide && !hi) return {ln(o,1), ln(e,1), ln(o,0), ln(e,0)};
        if (!wide &&  hi) return {ln(o,3), ln(e,3), ln(o,2), ln(e,2)};
        if ( wide && !hi) return {o[63:0], e[63:0]};
        return {o[127:64], e[127:64]};
    endfunction

    function automatic logic [127:0] exp_col(input int i, input logic [127:0] r0,
        input logic [127:0] r1, input logic [127:0] r2, input logic [127:0] r3);
        return {ln(r3,i), ln(r2,i), ln(r1,i), ln(r0,i)};
    endfunction

    task automatic t_reset;
        check(!xp_busy && !xp_done && !res_valid, "R9 flags", {125'd0, xp_busy, xp_done, res_valid}, '0);
        check(res == '0, "R9 res", res, '0);
        check((col0|col1|col2|col3) == '0, "R9 cols", col0|col1|col2|col3, '0);
    endtask

    task automatic t_op(input logic hi, input logic wide, input string req,
                        input logic [127:0] e, input logic [127:0] o);
        logic [127:0] exp;
        exp = exp_op(hi, wide, e, o);
        op_valid = 1'b1; op_hi = hi; op_wide = wide; op_even = e; op_odd = o;
        @(negedge clk);
        op_valid = 1'b0; op_even = ~e; op_odd = ~o;
        check(res_valid == 1'b1, {req, " R5 valid"}, {127'd0, res_valid}, 128'd1);
        check(res == exp, req, res, exp);
        @(negedge clk);
        check(res_valid == 1'b0 && res == exp, "R5 hold", res, exp);
    endtask

    task automatic t_xpose(input logic [127:0] r0, input logic [127:0] r1,
                           input logic [127:0] r2, input logic [127:0] r3,
                           input bit inject, input string tag);
        row0 = r0; row1 = r1; row2 = r2; row3 = r3; xp_start = 1'b1;
        @(negedge clk);
        xp_start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(xp_busy && !xp_done, {tag, " R7 busy"}, {126'd0, xp_busy, xp_done}, 128'd2);
            if (inject && i == 1) begin
                xp_start = 1'b1; row0 = ~r0; row1 = ~r1; row2 = ~r2; row3 = ~r3;
            end else begin
                xp_start = 1'b0;
            end
            @(negedge clk);
        end
        xp_start = 1'b0;
        check(xp_done && !xp_busy, {tag, " R7 done"}, {126'd0, xp_busy, xp_done}, 128'd1);
        check(col0 == exp_col(0, r0, r1, r2, r3), {tag, " R6 col0"}, col0, exp_col(0, r0, r1, r2, r3));
        check(col1 == exp_col(1, r0, r1, r2, r3), {tag, " R6 col1"}, col1, exp_col(1, r0, r1, r2, r3));
        check(col2 == exp_col(2, r0, r1, r2, r3), {tag, " R6 col2"}, col2, exp_col(2, r0, r1, r2, r3));
        check(col3 == exp_col(3, r0, r1, r2, r3), {tag, " R6 col3"}, col3, exp_col(3, r0, r1, r2, r3));
    endtask

    task automatic t_after(input logic [127:0] r0, input logic [127:0] r1,
                           input logic [127:0] r2, input logic [127:0] r3, input string tag);
        @(negedge clk);
        check(!xp_done && !xp_busy, {tag, " R10 pulse/R8 no extra"}, {126'd0, xp_busy, xp_done}, '0);
        check(col2 == exp_col(2, r0, r1, r2, r3), {tag, " R10 hold"}, col2, exp_col(2, r0, r1, r2, r3));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=%h exp=%h", 128'd0, 128'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [127:0] a, b, m0, m1, m2, m3;
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        a = 128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0;
        b = 128'hB3B3B3B3_B2B2B2B2_B1B1B1B1_B0B0B0B0;
        t_op(1'b0, 1'b0, "R1 lo32", a, b);
        t_op(1'b1, 1'b0, "R2 hi32", a, b);
        t_op(1'b0, 1'b1, "R3 lo64", a, b);
        t_op(1'b1, 1'b1, "R4 hi64", a, b);
        t_op(1'b0, 1'b0, "R1 lo32 swap", 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'hFFFF_0000_1234_5678_DEAD_BEEF_0BAD_F00D);

        m0 = {32'd4, 32'd3, 32'd2, 32'd1};
        m1 = {32'd8, 32'd7, 32'd6, 32'd5};
        m2 = {32'd12, 32'd11, 32'd10, 32'd9};
        m3 = {32'd16, 32'd15, 32'd14, 32'd13};
        t_xpose(m0, m1, m2, m3, 1'b0, "seq1");
        check(col0 == {32'd13, 32'd9, 32'd5, 32'd1}, "R6 literal col0", col0, {32'd13, 32'd9, 32'd5, 32'd1});
        t_after(m0, m1, m2, m3, "seq1");

        t_xpose(a, b, ~a, ~b, 1'b1, "seq2 inject");
        t_after(a, b, ~a, ~b, "seq2");

        // start in the done cycle is accepted (R10)
        t_xpose(m3, m2, m1, m0, 1'b0, "seq3");
        t_xpose(b, m1, a, m2, 1'b0, "R10 back-to-back");
        t_after(b, m1, a, m2, "seq4");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule